// File: doc/BRIEF.md
# One-Time-Programmable Word Memory Control Model

A synthesizable behavioural model of the control side of a 16-bit-wide, one-time-programmable memory. An active-low chip enable, a shared pin that is either an active-low output enable or, when a separate flag reports it at programming voltage, the program supply, a flag for the high-voltage identification level on address bit 9, a 21-bit address and a 16-bit data input set the operating mode. The block decodes six modes: standby, output disable, read, identification, program and program inhibit. It returns stored words or identification codes through a data output with a separate drive-enable. It also accepts program writes that can only clear bits.

The array model keeps 2^ARRAY_AW words (2^21 when ARRAY_AW equals ADDR_W). At the default ARRAY_AW of 8, the address bits above the stored range fold onto the lower words. The output drive-enable models the access delay as a count of clock cycles. An erase input and reset both return every word to all ones.

Top module: `otp_word_mem`

## Requirements
- R1: With chip enable high and the program supply not at high voltage (standby), data_oe_o is 0 at every edge after the first, whatever oe_ni holds.
- R2: With chip enable low, output enable high and the supply not high (output disable), data_oe_o stays 0.
- R3: With chip enable and output enable low and the supply not high (read), data_oe_o rises at the ACC_CYC-th rising edge (default 3) at which read conditions held. It is still 0 one edge earlier. At that edge data_o carries the addressed word.
- R4: With vpp_hi_i high, each low pulse of chip enable performs exactly one write, at the first edge where ce_ni is sampled low. The write stores old_word AND data_i, however many cycles the pulse lasts.
- R5: Programming can only clear bits. Writing data with a 1 where the stored bit is 0 leaves that bit 0.
- R6: With vpp_hi_i high (program or program inhibit), data_oe_o stays 0. With chip enable high in that state (inhibit), no word changes.
- R7: In read mode with id_hv_i high and every address bit except bits 0 and 9 zero, data_o is 16'h0020 when address bit 0 is 0 and 16'h0034 when it is 1. Bits 15 to 8 read as zero in both cases.
- R8: With id_hv_i high but any address bit other than 0 and 9 set, the read returns array data.
- R9: After reset, and at the edge after erase_i is sampled high, every word reads 16'hFFFF.
- R10: Words are indexed by addr_i[ARRAY_AW-1:0]. Distinct indices hold independent data. An address that differs only above that range (for example 9'h100 against 0 at default) reads the same word.
- R11: After either enable rises during a read, data_oe_o is 0 at the next rising edge. data_o reads 0 whenever data_oe_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ce_ni | input | 1 | Active-low chip enable, program strobe |
| oe_ni | input | 1 | Active-low output enable (shared program-supply pin) |
| vpp_hi_i | input | 1 | Shared pin is at programming voltage |
| id_hv_i | input | 1 | Address bit 9 is at the identification voltage |
| erase_i | input | 1 | Synchronous erase of the whole array to all ones |
| addr_i | input | 21 | Word address |
| data_i | input | 16 | Data to program |
| data_o | output | 16 | Read data, zero when not driven |
| data_oe_o | output | 1 | Data output drive-enable (high impedance when 0) |

## Verification
The assertions assume that erase_i, addr_i and the mode inputs change only between clock edges. They also assume a program pulse keeps addr_i and data_i steady from its falling edge to the write edge. The one-write-per-pulse and only-clear checks rely on this. The bench drives every input on the falling clock edge and holds address and data for the whole of each program pulse. It releases chip enable only after the supply flag is settled. It samples only on falling edges, a fixed number of rising edges after each stimulus.

// File: rtl/otp_word_mem_pkg.sv
package otp_word_mem_pkg;
  typedef enum logic [2:0] {
    MODE_STANDBY,
    MODE_DISABLE,
    MODE_READ,
    MODE_IDENT,
    MODE_PROG,
    MODE_INHIBIT
  } mem_mode_e;

  localparam logic [7:0] MFR_ID = 8'h20;
  localparam logic [7:0] DEV_ID = 8'h34;
endpackage

// File: rtl/otp_mode_dec.sv
module otp_mode_dec
  import otp_word_mem_pkg::*;
#(
  parameter int ADDR_W = 21,
  parameter int ID_BIT = 9
) (
  input  logic              ce_ni,
  input  logic              oe_ni,
  input  logic              vpp_hi_i,
  input  logic              id_hv_i,
  input  logic [ADDR_W-1:0] addr_i,
  output mem_mode_e         mode_o
);
  localparam logic [ADDR_W-1:0] ONE     = {{(ADDR_W-1){1'b0}}, 1'b1};
  localparam logic [ADDR_W-1:0] ID_KEEP = ~((ONE << ID_BIT) | ONE);

  logic id_ok;
  assign id_ok = id_hv_i && ((addr_i & ID_KEEP) == '0);

  always_comb begin
    if (vpp_hi_i)   mode_o = ce_ni ? MODE_INHIBIT : MODE_PROG;
    else if (ce_ni) mode_o = MODE_STANDBY;
    else if (oe_ni) mode_o = MODE_DISABLE;
    else            mode_o = id_ok ? MODE_IDENT : MODE_READ;
  end
endmodule

// File: rtl/otp_array.sv
module otp_array #(
  parameter int ARRAY_AW = 8,
  parameter int DATA_W   = 16
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                erase_i,
  input  logic                wr_en_i,
  input  logic [ARRAY_AW-1:0] idx_i,
  input  logic [DATA_W-1:0]   wdata_i,
  output logic [DATA_W-1:0]   rdata_o
);
  localparam int DEPTH = 1 << ARRAY_AW;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
    end else if (erase_i) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
    end else if (wr_en_i) begin
      mem[idx_i] <= mem[idx_i] & wdata_i;  // cells only discharge
    end
  end

  assign rdata_o = mem[idx_i];

  logic [ARRAY_AW-1:0] chk_idx;
  logic [DATA_W-1:0]   chk_old;
  logic                chk_wr;
  logic                chk_er;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chk_idx <= '0;
      chk_old <= '1;
      chk_wr  <= 1'b0;
      chk_er  <= 1'b0;
    end else begin
      chk_idx <= idx_i;
      chk_old <= mem[idx_i];
      chk_wr  <= wr_en_i && !erase_i;
      chk_er  <= erase_i;
    end
  end

  assert_only_clear_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chk_wr |-> ((mem[chk_idx] & ~chk_old) == '0));

  assert_erase_all_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chk_er |-> ((mem[0] == '1) && (mem[DEPTH-1] == '1)));
endmodule

// File: rtl/otp_out_ctl.sv
module otp_out_ctl #(
  parameter int ACC_CYC = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic read_act_i,
  output logic drive_o
);
  localparam int CNT_W = $clog2(ACC_CYC + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(ACC_CYC);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt     <= '0;
      drive_o <= 1'b0;
    end else if (!read_act_i) begin
      cnt     <= '0;
      drive_o <= 1'b0;
    end else begin
      if (cnt != CNT_MAX) cnt <= cnt + 1'b1;
      drive_o <= (int'(cnt) + 1) >= ACC_CYC;
    end
  end

  assert_float_after_rise_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !read_act_i |=> !drive_o);

  assert_drive_holds_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (drive_o && read_act_i) |=> drive_o);
endmodule

// File: rtl/otp_word_mem.sv
module otp_word_mem
  import otp_word_mem_pkg::*;
#(
  parameter int ADDR_W   = 21,
  parameter int DATA_W   = 16,
  parameter int ARRAY_AW = 8,
  parameter int ID_BIT   = 9,
  parameter int ACC_CYC  = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ce_ni,
  input  logic              oe_ni,
  input  logic              vpp_hi_i,
  input  logic              id_hv_i,
  input  logic              erase_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] data_o,
  output logic              data_oe_o
);
  mem_mode_e         mode;
  logic              ce_q;
  logic              wr_en;
  logic              read_act;
  logic [DATA_W-1:0] arr_word;
  logic [DATA_W-1:0] sel_word;
  logic [DATA_W-1:0] word_q;

  otp_mode_dec #(.ADDR_W(ADDR_W), .ID_BIT(ID_BIT)) i_dec (
    .ce_ni    (ce_ni),
    .oe_ni    (oe_ni),
    .vpp_hi_i (vpp_hi_i),
    .id_hv_i  (id_hv_i),
    .addr_i   (addr_i),
    .mode_o   (mode)
  );

  // One write per chip-enable low pulse: strobe on the sampled falling edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ce_q <= 1'b1;
    else         ce_q <= ce_ni;
  end
  assign wr_en = (mode == MODE_PROG) && ce_q;

  otp_array #(.ARRAY_AW(ARRAY_AW), .DATA_W(DATA_W)) i_array (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .erase_i (erase_i),
    .wr_en_i (wr_en),
    .idx_i   (addr_i[ARRAY_AW-1:0]),
    .wdata_i (data_i),
    .rdata_o (arr_word)
  );

  assign read_act = (mode == MODE_READ) || (mode == MODE_IDENT);

  otp_out_ctl #(.ACC_CYC(ACC_CYC)) i_out (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .read_act_i (read_act),
    .drive_o    (data_oe_o)
  );

  always_comb begin
    sel_word = arr_word;
    if (mode == MODE_IDENT)
      sel_word = DATA_W'(addr_i[0] ? DEV_ID : MFR_ID);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) word_q <= '0;
    else         word_q <= sel_word;
  end

  assign data_o = data_oe_o ? word_q : '0;

  assert_one_write_per_pulse_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en |=> !wr_en);

  assert_standby_float_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ce_ni && !vpp_hi_i) |=> !data_oe_o);

  assert_prog_float_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vpp_hi_i |=> !data_oe_o);

  assert_disable_float_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ce_ni && oe_ni && !vpp_hi_i) |=> !data_oe_o);
endmodule

// File: tb/test_otp_word_mem.sv
module test_otp_word_mem;
  localparam int ACC = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ce_n = 1'b1, oe_n = 1'b1, vpp = 1'b0, idhv = 1'b0, erase = 1'b0;
  logic [20:0] addr = '0;
  logic [15:0] din = '0;
  logic [15:0] dout;
  logic        doe;

  int n_chk = 0;
  int n_err = 0;
  bit done = 0;

  always #10 clk = ~clk;

  otp_word_mem i_otp_word_mem (
    .clk_i(clk), .rst_ni(rst_n), .ce_ni(ce_n), .oe_ni(oe_n), .vpp_hi_i(vpp),
    .id_hv_i(idhv), .erase_i(erase), .addr_i(addr), .data_i(din),
    .data_o(dout), .data_oe_o(doe)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // read with access-delay check, then release via chip or output enable
  task automatic rd(input string req, input logic [20:0] a, input logic [15:0] exp,
                    input bit drop_oe);
    @(negedge clk);
    addr = a; ce_n = 0; oe_n = 0; vpp = 0;
    cyc(ACC - 1);
    chk({req, " R3 not yet driven"}, 16'(doe), 16'd0);
    cyc(1);
    chk({req, " R3 driven"}, 16'(doe), 16'd1);
    chk(req, dout, exp);
    if (drop_oe) oe_n = 1; else ce_n = 1;
    cyc(1);
    chk("R11 float after enable rise", 16'(doe), 16'd0);
    chk("R11 data zero when floating", dout, 16'd0);
    ce_n = 1; oe_n = 1;
  endtask

  task automatic prog(input logic [20:0] a, input logic [15:0] d, input int len);
    @(negedge clk);
    vpp = 1; oe_n = 1; ce_n = 1; addr = a; din = d;
    cyc(1);
    ce_n = 0;
    for (int i = 0; i < len; i++) begin
      cyc(1);
      chk("R6 float while supply high", 16'(doe), 16'd0);
    end
    ce_n = 1;
    cyc(1);
    vpp = 0;
  endtask

  task automatic t_reset;
    chk("R9 no drive in reset", 16'(doe), 16'd0);
    rd("R9 reset word 0", 21'h0, 16'hFFFF, 0);
    rd("R9 reset top word", 21'hFF, 16'hFFFF, 1);
  endtask

  task automatic t_standby_disable;
    @(negedge clk);
    ce_n = 1; oe_n = 0; vpp = 0;
    cyc(ACC + 2);
    chk("R1 standby with oe low", 16'(doe), 16'd0);
    ce_n = 0; oe_n = 1;
    cyc(ACC + 2);
    chk("R2 output disable", 16'(doe), 16'd0);
    ce_n = 1;
  endtask

  task automatic t_program;
    prog(21'h0, 16'h00FF, 3);
    rd("R4 first pulse long", 21'h0, 16'h00FF, 0);
    prog(21'h0, 16'hF0F0, 1);
    rd("R4 second pulse AND", 21'h0, 16'h00F0, 0);
    prog(21'h0, 16'hFFFF, 2);
    rd("R5 ones do not set bits", 21'h0, 16'h00F0, 1);
    prog(21'h4, 16'h1234, 1);
    rd("R10 independent word", 21'h4, 16'h1234, 0);
    rd("R10 word 0 unchanged", 21'h0, 16'h00F0, 0);
    rd("R10 folded address", 21'h100, 16'h00F0, 0);
  endtask

  task automatic t_inhibit;
    @(negedge clk);
    vpp = 1; ce_n = 1; oe_n = 1; addr = 21'h5; din = 16'h0000;
    cyc(4);
    chk("R6 inhibit float", 16'(doe), 16'd0);
    vpp = 0;
    rd("R6 inhibit no write", 21'h5, 16'hFFFF, 0);
  endtask

  task automatic t_ident;
    idhv = 1;
    rd("R7 manufacturer code", 21'h0, 16'h0020, 0);
    rd("R7 device code", 21'h1, 16'h0034, 1);
    rd("R7 bit 9 set still id", 21'h201, 16'h0034, 0);
    rd("R8 other bit set gives array", 21'h4, 16'h1234, 0);
    rd("R8 high bit set gives array", 21'h100000, 16'h00F0, 0);
    idhv = 0;
    rd("R7 flag low gives array", 21'h1, 16'hFFFF, 0);
  endtask

  task automatic t_erase;
    @(negedge clk);
    erase = 1;
    cyc(1);
    erase = 0;
    rd("R9 erase word 0", 21'h0, 16'hFFFF, 0);
    rd("R9 erase word 4", 21'h4, 16'hFFFF, 0);
  endtask

  initial begin
    cyc(3);
    rst_n = 1;
    t_reset();
    t_standby_disable();
    t_program();
    t_inhibit();
    t_ident();
    t_erase();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_err++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule